// File: doc/BRIEF.md
# DMA Channel Service Sequencer

This block walks a small set of DMA channels and moves each channel that is ready forward by one step of transfer progress. A channel is ready when software has left it unmasked and a device holds a request on it. For every ready channel the sequencer runs one exchange with an external transfer agent. It hands over the channel identifier, the progress made so far and the total transfer length. The agent answers with a new progress value, which the sequencer stores. When that value reaches the length, the sequencer raises a one-cycle terminal-count pulse for that channel.

A device raises or drops its request with a pulse on the hold or release input. Either pulse also starts a pass over the channels, and so does the separate kick input, which a register front end pulses after changing the mask. A pass always goes from the lowest channel to the highest. When a pass has served at least one channel, another pass follows at once. A trigger that arrives while a pass is running is remembered, and it causes one more pass. With nothing ready, the sequencer goes back to idle. The word-shift parameter selects byte or word channels. It scales the transfer length and shifts the identifier sent to the agent.

Top module: `dma_svc_seq`

## Requirements
- R1: A channel is offered to the agent only when its `chan_mask_i` bit is 0 and its request bit (`req_bits_o`, bit n for channel n) is 1.
- R2: Within a pass, channels are offered in ascending order. With channels 1 and 3 ready and nothing else, the offers go 1, 3, 1, 3, and so on.
- R3: The offered length is (base count of the channel + 1) shifted left by WSHIFT. Base counts are packed in `base_cnt_i` with channel n at bits [n*CNT_W +: CNT_W].
- R4: The offered identifier is the channel number plus WSHIFT*NCH, and the offered position is the channel's stored progress. The agent's returned progress appears on `progress_o` (channel n at bits [n*LEN_W +: LEN_W]) in the cycle after the response.
- R5: In the cycle after a response whose returned progress equals the offered length, `tc_set_o` has exactly the bit of that channel set for one cycle. Otherwise `tc_set_o` stays 0.
- R6: A pass that served any channel is followed by a new pass, so a ready channel keeps being served, including after terminal count.
- R7: A trigger (hold, release or kick) that arrives during a pass causes a further pass after the current one ends.
- R8: A hold pulse sets the request bit of that channel from the next cycle on, and a release pulse clears it. When both pulses hit the same channel together, release wins. Each pulse starts a pass.
- R9: While `agt_req_valid_o` is high and `agt_req_ready_i` is low, the offer stays up with identifier, position and length unchanged.
- R10: After reset, request bits, progress and `tc_set_o` are all zero. No offer is ever made while no channel is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_mask_i | input | NCH | Per-channel mask; 1 blocks service |
| hold_i | input | NCH | Per-channel pulse that sets the request bit |
| release_i | input | NCH | Per-channel pulse that clears the request bit |
| kick_i | input | 1 | Pulse that starts a pass |
| base_cnt_i | input | NCH*CNT_W | Programmed base count of each channel |
| agt_req_valid_o | output | 1 | Offer to the transfer agent is valid |
| agt_req_ready_i | input | 1 | Agent accepts the offer |
| agt_req_id_o | output | $clog2(NCH)+1 | Channel identifier, including the word-shift offset |
| agt_req_pos_o | output | LEN_W | Current progress of the offered channel |
| agt_req_len_o | output | LEN_W | Transfer length of the offered channel |
| agt_rsp_valid_i | input | 1 | Agent returns new progress |
| agt_rsp_pos_i | input | LEN_W | Returned progress |
| req_bits_o | output | NCH | Request bits held per channel |
| progress_o | output | NCH*LEN_W | Stored progress of each channel |
| tc_set_o | output | NCH | One-cycle terminal-count pulse per channel |

## Verification
The bound checker watches several things on every cycle. It confirms that each new offer goes to a channel that was ready, and that the offered length and identifier offset match the base count and the shift. It confirms that a stalled offer stays unchanged. It checks that terminal-count pulses are one-hot and come only when the stored progress equals the length, and that hold and release pulses act on the request bits. Some behaviour only the bench scenarios can show: the ascending order across passes, the endless re-scanning after work, and a trigger caught in the middle of a pass that brings a late-unmasked channel into service. The bench also shows that with nothing ready, no offer is ever made.

// File: rtl/dma_svc_pkg.sv
package dma_svc_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_ISSUE = 2'd2,
      ST_WAIT  = 2'd3
   } svc_state_e;
endpackage

// File: rtl/dma_svc_req.sv
module dma_svc_req #(
   parameter int NCH = 4
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NCH-1:0] hold_i,
   input  logic [NCH-1:0] release_i,
   output logic [NCH-1:0] req_o,
   output logic           trig_o
);
   // release takes priority over hold on the same channel
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_o <= '0;
      else        req_o <= (req_o | hold_i) & ~release_i;
   end

   assign trig_o = |{hold_i, release_i};
endmodule

// File: rtl/dma_svc_len.sv
module dma_svc_len #(
   parameter int NCH    = 4,
   parameter int CNT_W  = 16,
   parameter int WSHIFT = 0,
   parameter int LEN_W  = CNT_W + 1 + WSHIFT
) (
   input  logic [NCH-1:0][CNT_W-1:0] base_i,
   output logic [NCH-1:0][LEN_W-1:0] len_o
);
   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic [LEN_W-1:0] plus_one;
      assign plus_one = LEN_W'(base_i[c]) + LEN_W'(1);
      if (WSHIFT == 0) begin : g_byte
         assign len_o[c] = plus_one;
      end else begin : g_word
         assign len_o[c] = plus_one << WSHIFT;
      end
   end
endmodule

// File: rtl/dma_svc_fsm.sv
module dma_svc_fsm
   import dma_svc_pkg::*;
#(
   parameter int NCH    = 4,
   parameter int LEN_W  = 17,
   parameter int WSHIFT = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NCH-1:0]            mask_i,
   input  logic [NCH-1:0]            req_i,
   input  logic                      trig_i,
   input  logic [NCH-1:0][LEN_W-1:0] len_i,
   input  logic [NCH-1:0][LEN_W-1:0] prog_i,
   input  logic                      req_ready_i,
   input  logic                      rsp_valid_i,
   input  logic [LEN_W-1:0]          rsp_pos_i,
   output logic                      req_valid_o,
   output logic [$clog2(NCH):0]      req_id_o,
   output logic [LEN_W-1:0]          req_pos_o,
   output logic [LEN_W-1:0]          req_len_o,
   output logic                      take_o,
   output logic [$clog2(NCH)-1:0]    take_idx_o,
   output logic [NCH-1:0]            tc_o
);
   localparam int IDX_W = $clog2(NCH);
   localparam int ID_W  = IDX_W + 1;

   svc_state_e       state;
   logic [IDX_W-1:0] idx;
   logic             worked;
   logic             pend;
   logic [NCH-1:0]   tc_q;
   logic             elig;
   logic             last;
   logic             rescan;

   assign elig   = ~mask_i[idx] & req_i[idx];
   assign last   = (idx == IDX_W'(NCH - 1));
   assign rescan = worked | pend | trig_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         idx    <= '0;
         worked <= 1'b0;
         pend   <= 1'b0;
         tc_q   <= '0;
      end else begin
         tc_q <= '0;
         if (state != ST_IDLE && trig_i) pend <= 1'b1;
         unique case (state)
            ST_IDLE: begin
               if (trig_i) begin
                  state  <= ST_SCAN;
                  idx    <= '0;
                  worked <= 1'b0;
                  pend   <= 1'b0;
               end
            end
            ST_SCAN: begin
               if (elig) begin
                  state <= ST_ISSUE;
               end else if (last) begin
                  if (rescan) begin
                     idx    <= '0;
                     worked <= 1'b0;
                     pend   <= 1'b0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else begin
                  idx <= idx + IDX_W'(1);
               end
            end
            ST_ISSUE: begin
               if (req_ready_i) state <= ST_WAIT;
            end
            ST_WAIT: begin
               if (rsp_valid_i) begin
                  tc_q[idx] <= (rsp_pos_i == len_i[idx]);
                  state     <= ST_SCAN;
                  if (last) begin
                     idx    <= '0;
                     worked <= 1'b0;
                     pend   <= 1'b0;
                  end else begin
                     idx    <= idx + IDX_W'(1);
                     worked <= 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_valid_o = (state == ST_ISSUE);
   assign req_id_o    = ID_W'(idx) + ID_W'(WSHIFT * NCH);
   assign req_pos_o   = prog_i[idx];
   assign req_len_o   = len_i[idx];
   assign take_o      = (state == ST_WAIT) & rsp_valid_i;
   assign take_idx_o  = idx;
   assign tc_o        = tc_q;
endmodule

// File: rtl/dma_svc_seq.sv
module dma_svc_seq #(
   parameter int NCH    = 4,
   parameter int CNT_W  = 16,
   parameter int WSHIFT = 0,
   parameter int LEN_W  = CNT_W + 1 + WSHIFT
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [NCH-1:0]          chan_mask_i,
   input  logic [NCH-1:0]          hold_i,
   input  logic [NCH-1:0]          release_i,
   input  logic                    kick_i,
   input  logic [NCH*CNT_W-1:0]    base_cnt_i,
   output logic                    agt_req_valid_o,
   input  logic                    agt_req_ready_i,
   output logic [$clog2(NCH):0]    agt_req_id_o,
   output logic [LEN_W-1:0]        agt_req_pos_o,
   output logic [LEN_W-1:0]        agt_req_len_o,
   input  logic                    agt_rsp_valid_i,
   input  logic [LEN_W-1:0]        agt_rsp_pos_i,
   output logic [NCH-1:0]          req_bits_o,
   output logic [NCH*LEN_W-1:0]    progress_o,
   output logic [NCH-1:0]          tc_set_o
);
   localparam int IDX_W = $clog2(NCH);

   if (NCH < 2 || (NCH & (NCH - 1)) != 0) begin : g_bad_nch
      $error("NCH must be a power of two, at least 2");
   end
   if (WSHIFT < 0 || WSHIFT > 1) begin : g_bad_shift
      $error("WSHIFT must be 0 or 1");
   end
   if (LEN_W < CNT_W + 1 + WSHIFT) begin : g_bad_len
      $error("LEN_W too narrow for the scaled length");
   end

   logic [NCH-1:0][CNT_W-1:0] base_a;
   logic [NCH-1:0][LEN_W-1:0] len_a;
   logic [NCH-1:0][LEN_W-1:0] prog_q;
   logic                      trig_req;
   logic                      trig_all;
   logic                      take;
   logic [IDX_W-1:0]          take_idx;

   assign base_a   = base_cnt_i;
   assign trig_all = trig_req | kick_i;

   dma_svc_req #(.NCH(NCH)) u_req (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_i   (hold_i),
      .release_i(release_i),
      .req_o    (req_bits_o),
      .trig_o   (trig_req)
   );

   dma_svc_len #(.NCH(NCH), .CNT_W(CNT_W), .WSHIFT(WSHIFT), .LEN_W(LEN_W)) u_len (
      .base_i(base_a),
      .len_o (len_a)
   );

   dma_svc_fsm #(.NCH(NCH), .LEN_W(LEN_W), .WSHIFT(WSHIFT)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_i     (chan_mask_i),
      .req_i      (req_bits_o),
      .trig_i     (trig_all),
      .len_i      (len_a),
      .prog_i     (prog_q),
      .req_ready_i(agt_req_ready_i),
      .rsp_valid_i(agt_rsp_valid_i),
      .rsp_pos_i  (agt_rsp_pos_i),
      .req_valid_o(agt_req_valid_o),
      .req_id_o   (agt_req_id_o),
      .req_pos_o  (agt_req_pos_o),
      .req_len_o  (agt_req_len_o),
      .take_o     (take),
      .take_idx_o (take_idx),
      .tc_o       (tc_set_o)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_prog
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                prog_q[c] <= '0;
         else if (take && take_idx == IDX_W'(c))    prog_q[c] <= agt_rsp_pos_i;
      end
   end

   assign progress_o = prog_q;
endmodule

// File: rtl/dma_svc_chk.sv
module dma_svc_chk #(
   parameter int NCH    = 4,
   parameter int CNT_W  = 16,
   parameter int WSHIFT = 0,
   parameter int LEN_W  = CNT_W + 1 + WSHIFT
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NCH-1:0]       chan_mask_i,
   input logic [NCH-1:0]       hold_i,
   input logic [NCH-1:0]       release_i,
   input logic [NCH*CNT_W-1:0] base_cnt_i,
   input logic                 agt_req_valid_o,
   input logic                 agt_req_ready_i,
   input logic [$clog2(NCH):0] agt_req_id_o,
   input logic [LEN_W-1:0]     agt_req_pos_o,
   input logic [LEN_W-1:0]     agt_req_len_o,
   input logic [NCH-1:0]       req_bits_o,
   input logic [NCH*LEN_W-1:0] progress_o,
   input logic [NCH-1:0]       tc_set_o
);
   localparam int IDX_W = $clog2(NCH);
   localparam int ID_W  = IDX_W + 1;

   logic [NCH-1:0][CNT_W-1:0] base_a;
   logic [NCH-1:0][LEN_W-1:0] prog_a;
   logic [NCH-1:0][LEN_W-1:0] len_ref;
   logic [IDX_W-1:0]          offer_ch;
   logic [NCH-1:0]            ready_set;

   assign base_a    = base_cnt_i;
   assign prog_a    = progress_o;
   assign offer_ch  = agt_req_id_o[IDX_W-1:0];
   assign ready_set = req_bits_o & ~chan_mask_i;

   for (genvar c = 0; c < NCH; c++) begin : g_ref
      assign len_ref[c] = (LEN_W'(base_a[c]) + LEN_W'(1)) << WSHIFT;

      AST_TC_AT_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
         tc_set_o[c] |-> (prog_a[c] == len_ref[c])); // R5
   end

   AST_TC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tc_set_o)); // R5

   AST_OFFER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(agt_req_valid_o) |-> $past(ready_set[offer_ch])); // R1

   AST_OFFER_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
      agt_req_valid_o |-> (agt_req_len_o == len_ref[offer_ch])); // R3

   AST_OFFER_ID_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
      agt_req_valid_o |-> (agt_req_id_o >= ID_W'(WSHIFT * NCH))); // R4

   AST_OFFER_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (agt_req_valid_o && !agt_req_ready_i) |=>
         (agt_req_valid_o && $stable(agt_req_id_o) && $stable(agt_req_pos_o)
          && $stable(agt_req_len_o))); // R9

   AST_HOLD_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hold_i & ~release_i)) |=>
         ((req_bits_o & $past(hold_i & ~release_i)) == $past(hold_i & ~release_i))); // R8

   AST_RELEASE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (|release_i) |=> ((req_bits_o & $past(release_i)) == '0)); // R8
endmodule

bind dma_svc_seq dma_svc_chk #(
   .NCH(NCH), .CNT_W(CNT_W), .WSHIFT(WSHIFT), .LEN_W(LEN_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .chan_mask_i    (chan_mask_i),
   .hold_i         (hold_i),
   .release_i      (release_i),
   .base_cnt_i     (base_cnt_i),
   .agt_req_valid_o(agt_req_valid_o),
   .agt_req_ready_i(agt_req_ready_i),
   .agt_req_id_o   (agt_req_id_o),
   .agt_req_pos_o  (agt_req_pos_o),
   .agt_req_len_o  (agt_req_len_o),
   .req_bits_o     (req_bits_o),
   .progress_o     (progress_o),
   .tc_set_o       (tc_set_o)
);

// File: tb/tb_dma_svc_seq.sv
`timescale 1ns/1ps
module tb_dma_svc_seq;
   localparam int NCH    = 4;
   localparam int CNT_W  = 8;
   localparam int WSHIFT = 1;
   localparam int LEN_W  = CNT_W + 1 + WSHIFT;
   localparam int STEP   = 5;

   logic                 clk = 1'b0;
   logic                 rst_n = 1'b0;
   logic [NCH-1:0]       chan_mask_i = '0;
   logic [NCH-1:0]       hold_i = '0;
   logic [NCH-1:0]       release_i = '0;
   logic                 kick_i = 1'b0;
   logic [NCH*CNT_W-1:0] base_cnt_i = {8'd2, 8'd1, 8'd5, 8'd3};
   logic                 agt_req_valid_o;
   logic                 agt_req_ready_i = 1'b1;
   logic [2:0]           agt_req_id_o;
   logic [LEN_W-1:0]     agt_req_pos_o;
   logic [LEN_W-1:0]     agt_req_len_o;
   logic                 agt_rsp_valid_i = 1'b0;
   logic [LEN_W-1:0]     agt_rsp_pos_i = '0;
   logic [NCH-1:0]       req_bits_o;
   logic [NCH*LEN_W-1:0] progress_o;
   logic [NCH-1:0]       tc_set_o;

   always #4 clk = ~clk;

   dma_svc_seq #(.NCH(NCH), .CNT_W(CNT_W), .WSHIFT(WSHIFT)) dut (.*);

   int n_cmp = 0, n_bad = 0, nreq = 0, ntc = 0;
   int model_prog [NCH];
   int base_v [NCH] = '{3, 5, 1, 2};
   int seq_q [$];
   logic [NCH-1:0] model_req = '0;
   logic [NCH-1:0] snap_elig = '0;
   logic [NCH-1:0] exp_tc = '0;
   bit stall = 0, started = 0, finished = 0;

   task automatic chk(string tag, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   function automatic int len_of(int ch);
      return (base_v[ch] + 1) << WSHIFT;
   endfunction

   // reference request bits and the ready set seen at the previous edge
   always @(posedge clk) begin
      if (!rst_n) begin
         model_req <= '0;
         snap_elig <= '0;
      end else begin
         snap_elig <= model_req & ~chan_mask_i;
         model_req <= (model_req | hold_i) & ~release_i;
      end
   end

   // per-clock comparison of request bits, progress and terminal count
   always @(negedge clk) begin
      if (started) begin
         chk("R8 request bits", int'(req_bits_o), int'(model_req));
         for (int c = 0; c < NCH; c++)
            chk($sformatf("R4 progress ch%0d", c),
                int'(progress_o[c*LEN_W +: LEN_W]), model_prog[c]);
         chk("R5 terminal count", int'(tc_set_o), int'(exp_tc));
         exp_tc = '0;
      end
   end

   // transfer agent
   initial begin
      for (int c = 0; c < NCH; c++) model_prog[c] = 0;
      forever begin
         @(negedge clk);
         if (!agt_req_valid_o) agt_req_ready_i = !stall;
         if (rst_n && agt_req_valid_o) begin
            int ch, id0, newpos;
            ch  = int'(agt_req_id_o) - WSHIFT * NCH;
            id0 = int'(agt_req_id_o);
            chk("R4 id offset", (ch >= 0 && ch < NCH) ? 1 : 0, 1);
            if (ch < 0 || ch >= NCH) ch = 0;
            chk("R1 eligible", int'(snap_elig[ch]), 1);
            chk("R3 length", int'(agt_req_len_o), len_of(ch));
            chk("R4 position", int'(agt_req_pos_o), model_prog[ch]);
            seq_q.push_back(ch);
            nreq++;
            if (stall) begin
               repeat (2) begin
                  @(negedge clk);
                  chk("R9 valid held", int'(agt_req_valid_o), 1);
                  chk("R9 id held", int'(agt_req_id_o), id0);
               end
               agt_req_ready_i = 1'b1;
            end
            @(posedge clk);
            newpos = model_prog[ch] + STEP;
            if (newpos > len_of(ch)) newpos = len_of(ch);
            @(negedge clk);
            agt_req_ready_i = !stall;
            agt_rsp_valid_i = 1'b1;
            agt_rsp_pos_i   = LEN_W'(newpos);
            @(posedge clk);
            model_prog[ch] = newpos;
            if (newpos == len_of(ch)) begin
               exp_tc[ch] = 1'b1;
               ntc++;
            end
            @(negedge clk);
            agt_rsp_valid_i = 1'b0;
         end
      end
   end

   task automatic pulse(logic [NCH-1:0] h, logic [NCH-1:0] r, logic k);
      @(negedge clk);
      hold_i = h; release_i = r; kick_i = k;
      @(posedge clk);
      @(negedge clk);
      hold_i = '0; release_i = '0; kick_i = 1'b0;
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      int n0;
      repeat (3) @(negedge clk);
      // R10 reset state
      chk("R10 reset req bits", int'(req_bits_o), 0);
      chk("R10 reset progress", int'(progress_o), 0);
      chk("R10 reset tc", int'(tc_set_o), 0);
      chk("R10 reset offer", int'(agt_req_valid_o), 0);
      rst_n = 1'b1;
      started = 1;
      repeat (5) @(negedge clk);

      // R10 nothing ready: a kick makes no offer
      pulse('0, '0, 1'b1);
      repeat (20) @(negedge clk);
      chk("R10 idle no offer", nreq, 0);

      // R2 / R6: channels 1 and 3 served alternately across passes
      seq_q.delete();
      pulse(4'b1010, '0, 1'b0);
      while (nreq < 12) @(negedge clk);
      for (int k = 0; k < 8; k++)
         chk($sformatf("R2 order slot %0d", k), seq_q[k], (k % 2) ? 3 : 1);
      chk("R6 repeated service", (nreq >= 12) ? 1 : 0, 1);
      chk("R5 terminal count seen", (ntc > 0) ? 1 : 0, 1);

      // R8 release wins over hold on the same channel
      pulse(4'b0100, 4'b0100, 1'b0);
      chk("R8 release priority", int'(req_bits_o[2]), 0);

      // R10 release all, then no more offers
      pulse('0, 4'b1010, 1'b0);
      repeat (30) @(negedge clk);
      n0 = nreq;
      repeat (30) @(negedge clk);
      chk("R10 idle after release", nreq, n0);

      // R9 stalled offers
      stall = 1;
      repeat (2) @(negedge clk);
      pulse(4'b0001, '0, 1'b0);
      while (nreq < n0 + 3) @(negedge clk);
      pulse('0, 4'b0001, 1'b0);
      repeat (30) @(negedge clk);
      stall = 0;
      repeat (2) @(negedge clk);

      // R7 control: unmask mid-pass without a trigger, nothing happens
      chan_mask_i = 4'hF;
      pulse(4'b0001, '0, 1'b0);
      repeat (10) @(negedge clk);
      n0 = nreq;
      pulse('0, '0, 1'b1);
      @(negedge clk);
      chan_mask_i = 4'hE;
      repeat (20) @(negedge clk);
      chk("R7 no trigger no service", nreq, n0);

      // R7: same, with a kick during the pass
      chan_mask_i = 4'hF;
      repeat (10) @(negedge clk);
      pulse('0, '0, 1'b1);
      @(negedge clk);
      chan_mask_i = 4'hE;
      kick_i = 1'b1;
      @(negedge clk);
      kick_i = 1'b0;
      repeat (20) @(negedge clk);
      chk("R7 pending trigger served", (nreq > n0) ? 1 : 0, 1);

      pulse('0, 4'b0001, 1'b0);
      repeat (30) @(negedge clk);
      finish_run();
   end
endmodule